// File: doc/BRIEF.md
# Shared MDIO Management Arbiter with PHY Address Locking

This block lets several requesters share one external MDIO management master. Requester 0 is a privileged global port and may reach any PHY address on the bus. Requesters 1 to `NUM_PORTS` are per-port requesters. Each of them is locked to one PHY address, which is programmed through a per-port write strobe. Every requester raises a Clause 22 read or write request and holds it until it sees a one-cycle acknowledge. The acknowledge carries an error flag and, for reads, the 16-bit data.

A round-robin arbiter picks one pending request while the serial engine is idle. A per-port request aimed at a PHY address other than the locked one is refused: it causes no bus activity and is acknowledged at once with the error flag. An accepted request is serialised as a complete frame on MDC/MDIO. The next request is granted only after that frame has finished. MDC is the system clock divided by the even ratio `CLK_DIV`. The master changes MDIO only when MDC falls and samples it when MDC rises.

Top module: `mdio_share_arb`

## Requirements
- R1: Requester 0 may access any PHY address. Its requests are always carried out on the bus and acknowledged with the error flag low.
- R2: A per-port requester i (1..NUM_PORTS) whose request PHY address equals its locked address gets a full bus frame and a clean acknowledge.
- R3: A per-port request whose PHY address differs from its locked address produces no MDC edge. It is acknowledged no more than 2 clock cycles after it is presented, with `ackErr` high and `ackRdata` zero.
- R4: A write frame is 64 bits, sent MSB first: 32 ones, start `01`, opcode `01`, 5-bit PHY address, 5-bit register address, turnaround `10`, then 16 data bits. `mdioOe` stays high for all 64 bits.
- R5: A read frame uses opcode `10` and the same header. `mdioOe` is low from frame bit 46 (the turnaround) to the end of the frame. The 16 data bits are sampled on the rising MDC edges of frame bits 48..63, MSB first, and returned on `ackRdata`.
- R6: Only one access is in progress at a time. Each granted access completes all 64 MDC cycles before its acknowledge, and `ackValid` is never high for more than one requester.
- R7: Arbitration is round-robin. The requester granted last, including a refused one, has the lowest priority next time. After reset, requester 0 has the highest priority.
- R8: A locked-address write (`presetWe[i-1]` with `presetData`) takes effect only when the block is idle. A strobe during an access is ignored.
- R9: MDC is high for `CLK_DIV/2` clocks and low for `CLK_DIV/2` clocks per bit. While `mdioOe` is held, `mdioOut` changes only on a falling MDC edge.
- R10: After reset MDC is low, `mdioOe` is low, no acknowledge is pending, and every locked address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | NUM_PORTS+1 | Request pending, one bit per requester, held until acknowledged |
| reqWrite | input | NUM_PORTS+1 | 1 = write, 0 = read, per requester |
| reqPhy | input | 5*(NUM_PORTS+1) | PHY address per requester, requester i in bits [5i+4:5i] |
| reqReg | input | 5*(NUM_PORTS+1) | Register address per requester |
| reqWdata | input | 16*(NUM_PORTS+1) | Write data per requester |
| ackValid | output | NUM_PORTS+1 | One-cycle acknowledge to the served requester |
| ackErr | output | 1 | Error flag valid with ackValid |
| ackRdata | output | 16 | Read data valid with ackValid |
| presetWe | input | NUM_PORTS | Locked-address write strobe for per-port requesters 1..NUM_PORTS |
| presetData | input | 5 | Locked address value to write |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable (1 = master drives) |
| mdioIn | input | 1 | MDIO value seen on the pin |

## Verification
The bench goes after four kinds of error. The first is a refused per-port access that leaks onto the bus. A filter placed after the engine start would show MDC edges or a late acknowledge. The second is a preset strobe that lands during a frame. A design that does not gate it would lock the port to the new address, so the old address would be refused afterwards. The third is round-robin order when every requester is pending at once. A fixed-priority arbiter, or one that forgets to demote a refused grant, would serve the requests in the wrong order. The fourth is the read turnaround and the data sampling point. Releasing MDIO one bit late, or sampling on the wrong MDC edge, would shift the returned data by one bit.

// File: rtl/mdio_share_pkg.sv
package mdio_share_pkg;
  localparam int PHY_W   = 5;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = 64;

  // Command handed from control to datapath in the cycle of a grant
  typedef struct packed {
    logic              start;
    logic              isRead;
    logic [PHY_W-1:0]  phy;
    logic [PHY_W-1:0]  regAddr;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_ACK} arb_state_e;
endpackage

// File: rtl/mdio_share_dp.sv
module mdio_share_dp
  import mdio_share_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mdio_cmd_t         cmd,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int HALF   = CLK_DIV / 2;
  localparam int DIV_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam int TA_BIT = 46;
  localparam int RD_BIT = 48;
  localparam logic [DIV_W-1:0] RISE_AT = DIV_W'(HALF - 1);
  localparam logic [DIV_W-1:0] FALL_AT = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [FRAME_W-1:0] shiftReg;
  logic               isRd;
  logic               mdcR;
  logic [DATA_W-1:0]  rdSr;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    frame = {32'hFFFF_FFFF, 2'b01,
             cmd.isRead ? 2'b10 : 2'b01,
             cmd.phy, cmd.regAddr,
             cmd.isRead ? 2'b11 : 2'b10,
             cmd.isRead ? 16'hFFFF : cmd.wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      isRd     <= 1'b0;
      mdcR     <= 1'b0;
      rdSr     <= '0;
    end else if (cmd.start) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      shiftReg <= frame;
      isRd     <= cmd.isRead;
      mdcR     <= 1'b0;
      rdSr     <= '0;
    end else if (busy) begin
      done <= 1'b0;
      if (divCnt == RISE_AT) begin
        mdcR   <= 1'b1;
        divCnt <= divCnt + 1'b1;
        if (isRd && (bitCnt >= BIT_W'(RD_BIT)))
          rdSr <= {rdSr[DATA_W-2:0], mdioIn};
      end else if (divCnt == FALL_AT) begin
        mdcR     <= 1'b0;
        divCnt   <= '0;
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
        if (bitCnt == LAST_BIT) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign mdc     = mdcR;
  assign mdioOut = busy & shiftReg[FRAME_W-1];
  assign mdioOe  = busy & (~isRd | (bitCnt < BIT_W'(TA_BIT)));
  assign rdata   = rdSr;
endmodule

// File: rtl/mdio_share_ctrl.sv
module mdio_share_ctrl
  import mdio_share_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS:0]                reqValid,
  input  logic [NUM_PORTS:0]                reqWrite,
  input  logic [(NUM_PORTS+1)*PHY_W-1:0]    reqPhy,
  input  logic [(NUM_PORTS+1)*PHY_W-1:0]    reqReg,
  input  logic [(NUM_PORTS+1)*DATA_W-1:0]   reqWdata,
  input  logic [NUM_PORTS-1:0]              presetWe,
  input  logic [PHY_W-1:0]                  presetData,
  input  logic                              dpDone,
  input  logic [DATA_W-1:0]                 dpRdata,
  output mdio_cmd_t                         cmd,
  output logic [NUM_PORTS:0]                ackValid,
  output logic                              ackErr,
  output logic [DATA_W-1:0]                 ackRdata,
  output logic                              idle
);
  localparam int NREQ  = NUM_PORTS + 1;
  localparam int IDX_W = $clog2(NREQ);

  arb_state_e       state;
  logic [IDX_W-1:0] lastGrant;
  logic [IDX_W-1:0] grantR;
  logic [IDX_W-1:0] winner;
  logic             anyReq;
  logic             allowed;
  logic             errR;
  logic [DATA_W-1:0] rdataR;
  logic [PHY_W-1:0] lockAddr [NUM_PORTS];
  logic [PHY_W-1:0] winPhy;

  assign idle = (state == ST_IDLE);

  // Round-robin search starting just after the last grant
  always_comb begin
    winner = '0;
    anyReq = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      int t;
      t = int'(lastGrant) + k;
      if (t >= NREQ) t = t - NREQ;
      if (!anyReq && reqValid[t]) begin
        anyReq = 1'b1;
        winner = IDX_W'(t);
      end
    end
  end

  always_comb begin
    winPhy  = reqPhy[winner*PHY_W +: PHY_W];
    allowed = 1'b1;
    for (int p = 1; p < NREQ; p++) begin
      if (winner == IDX_W'(p) && winPhy != lockAddr[p-1]) allowed = 1'b0;
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.start   = idle && anyReq && allowed;
    cmd.isRead  = ~reqWrite[winner];
    cmd.phy     = winPhy;
    cmd.regAddr = reqReg[winner*PHY_W +: PHY_W];
    cmd.wdata   = reqWdata[winner*DATA_W +: DATA_W];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lockAddr[g] <= '0;
        else if (presetWe[g] && idle) lockAddr[g] <= presetData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lastGrant <= IDX_W'(NREQ - 1);
      grantR    <= '0;
      errR      <= 1'b0;
      rdataR    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (anyReq) begin
          lastGrant <= winner;
          grantR    <= winner;
          if (allowed) begin
            state <= ST_BUSY;
          end else begin
            errR   <= 1'b1;
            rdataR <= '0;
            state  <= ST_ACK;
          end
        end
        ST_BUSY: if (dpDone) begin
          errR   <= 1'b0;
          rdataR <= dpRdata;
          state  <= ST_ACK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ackValid = '0;
    if (state == ST_ACK) ackValid[grantR] = 1'b1;
  end
  assign ackErr   = errR;
  assign ackRdata = rdataR;
endmodule

// File: rtl/mdio_share_arb.sv
module mdio_share_arb
  import mdio_share_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int CLK_DIV   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PORTS:0]              reqValid,
  input  logic [NUM_PORTS:0]              reqWrite,
  input  logic [(NUM_PORTS+1)*5-1:0]      reqPhy,
  input  logic [(NUM_PORTS+1)*5-1:0]      reqReg,
  input  logic [(NUM_PORTS+1)*16-1:0]     reqWdata,
  output logic [NUM_PORTS:0]              ackValid,
  output logic                            ackErr,
  output logic [15:0]                     ackRdata,
  input  logic [NUM_PORTS-1:0]            presetWe,
  input  logic [4:0]                      presetData,
  output logic                            mdc,
  output logic                            mdioOut,
  output logic                            mdioOe,
  input  logic                            mdioIn
);
  mdio_cmd_t   cmd;
  logic        dpDone;
  logic        dpBusy;
  logic        ctrlIdle;
  logic [15:0] dpRdata;

  mdio_share_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqPhy(reqPhy),
    .reqReg(reqReg), .reqWdata(reqWdata),
    .presetWe(presetWe), .presetData(presetData),
    .dpDone(dpDone), .dpRdata(dpRdata),
    .cmd(cmd), .ackValid(ackValid), .ackErr(ackErr),
    .ackRdata(ackRdata), .idle(ctrlIdle)
  );

  mdio_share_dp #(.CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .busy(dpBusy), .done(dpDone), .rdata(dpRdata)
  );
endmodule

// File: rtl/mdio_share_arb_chk.sv
module mdio_share_arb_chk #(
  parameter int NUM_PORTS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_PORTS:0] ackValid,
  input logic               ackErr,
  input logic [15:0]        ackRdata,
  input logic               mdc,
  input logic               mdioOut,
  input logic               mdioOe,
  input logic               dpBusy
);
  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ackValid));

  // R6
  ack_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid != '0) |-> (!dpBusy && !mdioOe));

  // R3
  reject_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ackValid != '0) && ackErr) |-> (ackRdata == 16'h0));

  // R9
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdioOe && $past(mdioOe) && (mdioOut != $past(mdioOut))) |-> $fell(mdc));

  // R10
  mdc_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dpBusy |-> (!mdc && !mdioOe));
endmodule

bind mdio_share_arb mdio_share_arb_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ackValid(ackValid), .ackErr(ackErr),
  .ackRdata(ackRdata), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .dpBusy(dpBusy)
);

// File: tb/mdio_share_arb_bench.sv
module mdio_share_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int NR = NP + 1;
  localparam int DIV = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [NP:0] reqValid = '0, reqWrite = '0;
  logic [NR*5-1:0] reqPhy = '0, reqReg = '0;
  logic [NR*16-1:0] reqWdata = '0;
  logic [NP:0] ackValid;
  logic ackErr;
  logic [15:0] ackRdata;
  logic [NP-1:0] presetWe = '0;
  logic [4:0] presetData = '0;
  logic mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int checks = 0, errors = 0;
  int mdcEdges = 0, highClks = 0, bitIdx = 0;
  logic [63:0] shadow = '0;
  logic [15:0] phyRdVal = 16'h0;
  int expLast = NR - 1;

  mdio_share_arb #(.NUM_PORTS(NP), .CLK_DIV(DIV)) u_mdio_share_arb (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqPhy(reqPhy), .reqReg(reqReg), .reqWdata(reqWdata),
    .ackValid(ackValid), .ackErr(ackErr), .ackRdata(ackRdata),
    .presetWe(presetWe), .presetData(presetData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: record bits on MDC rise, answer reads on MDC fall
  always @(posedge mdioOe) bitIdx = 0;
  always @(posedge mdc) begin
    mdcEdges++;
    if (bitIdx < 64) shadow[63-bitIdx] = mdioOe ? mdioOut : 1'b0;
    bitIdx++;
  end
  always @(negedge mdc) begin
    if (bitIdx == 47) mdioIn = 1'b0;
    else if (bitIdx >= 48 && bitIdx <= 63) mdioIn = phyRdVal[63-bitIdx];
    else mdioIn = 1'b1;
  end
  always @(posedge clk) if (mdc) highClks++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setReq(input int p, input bit wr, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] wd);
    reqWrite[p] = wr;
    reqPhy[p*5 +: 5] = phy;
    reqReg[p*5 +: 5] = rg;
    reqWdata[p*16 +: 16] = wd;
    reqValid[p] = 1'b1;
  endtask

  // Wait for an acknowledge (sampled at negedge), drop that request
  task automatic waitAck(output int who, output bit err,
                         output logic [15:0] rd, output int cyc);
    cyc = 0;
    who = -1;
    while (who < 0) begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < NR; i++) if (ackValid[i]) who = i;
    end
    err = ackErr;
    rd = ackRdata;
    reqValid[who] = 1'b0;
    expLast = who;
  endtask

  task automatic setLock(input int port, input logic [4:0] a);
    @(negedge clk);
    presetData = a;
    presetWe[port-1] = 1'b1;
    @(negedge clk);
    presetWe = '0;
  endtask

  task automatic testReset();
    chk(mdc == 0, "R10", "mdc after reset", mdc, 0);
    chk(mdioOe == 0, "R10", "oe after reset", mdioOe, 0);
    chk(ackValid == 0, "R10", "ack after reset", ackValid, 0);
  endtask

  task automatic testGlobalWrite();
    int who, cyc, e0, h0; bit err; logic [15:0] rd;
    @(negedge clk);
    e0 = mdcEdges; h0 = highClks;
    setReq(0, 1, 5'd9, 5'd4, 16'hA5C3);
    waitAck(who, err, rd, cyc);
    chk(who == 0 && err == 0, "R1", "global write ack/err", {who, err}, 0);
    chk(shadow == {32'hFFFFFFFF, 2'b01, 2'b01, 5'd9, 5'd4, 2'b10, 16'hA5C3},
        "R4", "write frame", shadow, 0);
    chk(mdcEdges - e0 == 64, "R6", "mdc edges per frame", mdcEdges - e0, 64);
    chk(highClks - h0 == 64 * DIV / 2, "R9", "mdc high clocks", highClks - h0, 64 * DIV / 2);
  endtask

  task automatic testGlobalRead();
    int who, cyc; bit err; logic [15:0] rd;
    @(negedge clk);
    phyRdVal = 16'h3C96;
    setReq(0, 0, 5'd30, 5'd17, 16'h0);
    waitAck(who, err, rd, cyc);
    chk(rd == 16'h3C96 && err == 0, "R5", "read data", rd, 16'h3C96);
    chk(shadow[63:18] == {32'hFFFFFFFF, 2'b01, 2'b10, 5'd30, 5'd17},
        "R5", "read header", shadow[63:18], 0);
    chk(shadow[17] == 0, "R5", "oe released at turnaround", shadow[17], 0);
  endtask

  task automatic testPortFilter();
    int who, cyc, e0; bit err; logic [15:0] rd;
    setLock(1, 5'd5);
    @(negedge clk);
    phyRdVal = 16'h1234;
    setReq(1, 0, 5'd5, 5'd2, 16'h0);
    waitAck(who, err, rd, cyc);
    chk(who == 1 && err == 0 && rd == 16'h1234, "R2", "port1 locked read", rd, 16'h1234);
    @(negedge clk);
    e0 = mdcEdges;
    setReq(1, 1, 5'd6, 5'd2, 16'hFFFF);
    waitAck(who, err, rd, cyc);
    chk(err == 1, "R3", "reject error flag", err, 1);
    chk(rd == 0, "R3", "reject rdata", rd, 0);
    chk(cyc <= 2, "R3", "reject latency", cyc, 2);
    repeat (3) @(negedge clk);
    chk(mdcEdges == e0, "R3", "no mdc on reject", mdcEdges - e0, 0);
  endtask

  task automatic testRoundRobin();
    int who, cyc, e0, exp; bit err; logic [15:0] rd;
    setLock(2, 5'd7);
    setLock(3, 5'd8);
    @(negedge clk);
    setReq(0, 1, 5'd1, 5'd0, 16'h0001);
    setReq(1, 1, 5'd5, 5'd0, 16'h0002);
    setReq(2, 1, 5'd7, 5'd0, 16'h0003);
    setReq(3, 1, 5'd8, 5'd0, 16'h0004);
    for (int n = 0; n < NR; n++) begin
      exp = (expLast + 1) % NR;
      e0 = mdcEdges;
      waitAck(who, err, rd, cyc);
      chk(who == exp, "R7", "round-robin order", who, exp);
      chk(mdcEdges - e0 == 64 && err == 0, "R6", "full frame per grant", mdcEdges - e0, 64);
    end
  endtask

  task automatic testLockWhileBusy();
    int who, cyc; bit err; logic [15:0] rd;
    @(negedge clk);
    setReq(0, 1, 5'd3, 5'd1, 16'hBEEF);
    repeat (20) @(negedge clk);
    presetData = 5'd20;
    presetWe[1] = 1'b1;
    @(negedge clk);
    presetWe = '0;
    waitAck(who, err, rd, cyc);
    @(negedge clk);
    setReq(2, 1, 5'd7, 5'd1, 16'h0);
    waitAck(who, err, rd, cyc);
    chk(err == 0, "R8", "old lock kept after busy strobe", err, 0);
    @(negedge clk);
    setReq(2, 1, 5'd20, 5'd1, 16'h0);
    waitAck(who, err, rd, cyc);
    chk(err == 1, "R8", "busy strobe ignored", err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    testGlobalWrite();
    testGlobalRead();
    testPortFilter();
    testRoundRobin();
    testLockWhileBusy();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule